// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the two open-drain lines of a two-wire serial bus, the clock line and the data line, and decodes the bus-level conditions from them. Both lines are pulled up, so both rest high when nobody drives them. A falling data line while the clock is high opens a transfer. A rising data line while the clock is high closes it. The monitor reports each of these as a one-cycle pulse on the system clock. It reports a second opening seen while a transfer is already in progress on its own pulse, as a repeated start.

The block also holds a busy level. A controller sharing the bus checks this level before it tries to claim the bus. The monitor pulses an error output when the data line moves during a clock-high period in a way that it cannot classify as an opening or a closing condition. Both lines are asynchronous to the system clock, so each passes through a multi-stage synchronizer before any edge is evaluated.

Top module: `i2c_cond_mon`

## Requirements
- R1: A line value present at system clock edge k affects the outputs registered at edge k+SYNC_STAGES. Events are found by comparing each synchronized sample with the sample one cycle earlier.
- R2: When the clock line is high in both samples, the data line goes from 1 to 0, and busy_o is 0, start_o pulses for one cycle and busy_o becomes 1 on the same edge.
- R3: The same clock-high falling data edge while busy_o is 1 pulses rstart_o instead of start_o, and busy_o stays 1.
- R4: When the clock line is high in both samples and the data line goes from 0 to 1, stop_o pulses and busy_o becomes 0. This also applies when the bus was already idle; busy_o then stays 0.
- R5: busy_o changes only on an edge where start_o or stop_o is asserted.
- R6: When the data line changes in the same sample step as the clock line, with the clock high on either side of the step, viol_o pulses. No start, repeated start or stop is reported for that step, and busy_o is unchanged.
- R7: A data line change while the clock line is low in both samples produces no pulse and leaves busy_o unchanged.
- R8: While rst_ni is low, all outputs are 0 and the synchronizer stages hold 1. Releasing reset with both lines high therefore produces no event.
- R9: At most one of start_o, rstart_o, stop_o and viol_o is high in any cycle, and each pulse lasts one cycle per qualifying sample step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| start_o | output | 1 | Start from idle, one-cycle pulse |
| rstart_o | output | 1 | Start while busy, one-cycle pulse |
| stop_o | output | 1 | Stop condition, one-cycle pulse |
| viol_o | output | 1 | Illegal data change during clock high, one-cycle pulse |
| busy_o | output | 1 | Bus owned by a transfer |

## Verification
The bench builds the monitor with SYNC_STAGES set to 3 instead of the default 2. This checks that the input-to-output latency follows the parameter rather than a fixed pipeline, and it exercises the generate loop beyond two stages. The expected value of every output is computed each cycle from the bench's own record of driven line values, taken SYNC_STAGES and SYNC_STAGES+1 cycles back. Directed sequences reach a repeated start, a stop on an idle bus and simultaneous edges in both bus states. Random toggling then covers mixed orderings.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef enum logic [1:0] {
    COND_NONE  = 2'd0,
    COND_START = 2'd1,
    COND_STOP  = 2'd2,
    COND_VIOL  = 2'd3
  } cond_e;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '1;   // lines idle high
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '1;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_detect.sv
module i2c_mon_detect
  import i2c_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_s_i,
  input  logic  sda_s_i,
  output cond_e cond_o
);
  logic scl_q, sda_q;
  logic scl_hi, sda_chg, scl_chg;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end

  assign scl_hi  = scl_q & scl_s_i;
  assign scl_chg = scl_q ^ scl_s_i;
  assign sda_chg = sda_q ^ sda_s_i;

  always_comb begin
    cond_o = COND_NONE;
    if (sda_chg) begin
      if (scl_chg)     cond_o = COND_VIOL;   // order of edges unknown
      else if (scl_hi) cond_o = sda_s_i ? COND_STOP : COND_START;
    end
  end

  p_start_sda_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o == COND_START |=> !sda_q && scl_q);
  p_low_scl_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_q && !scl_s_i) |-> cond_o == COND_NONE);
endmodule

// File: rtl/i2c_mon_track.sv
module i2c_mon_track
  import i2c_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cond_e cond_i,
  output logic  start_o,
  output logic  rstart_o,
  output logic  stop_o,
  output logic  viol_o,
  output logic  busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= 1'b0;
      viol_o   <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      start_o  <= (cond_i == COND_START) && !busy_o;
      rstart_o <= (cond_i == COND_START) &&  busy_o;
      stop_o   <= (cond_i == COND_STOP);
      viol_o   <= (cond_i == COND_VIOL);
      if (cond_i == COND_START)     busy_o <= 1'b1;
      else if (cond_i == COND_STOP) busy_o <= 1'b0;
    end

  p_start_sets_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o && !$past(busy_o));
  p_rstart_keeps_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> busy_o && $past(busy_o));
  p_stop_frees_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !busy_o);
  p_busy_moves_on_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != $past(busy_o)) |-> (start_o || stop_o));
  p_viol_keeps_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $stable(busy_o));
  p_one_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, rstart_o, stop_o, viol_o}));
endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic viol_o,
  output logic busy_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] lines_s;
  cond_e            cond;

  i2c_mon_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2c_mon_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(lines_s[1]),
    .sda_s_i(lines_s[0]),
    .cond_o (cond)
  );

  i2c_mon_track u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_i  (cond),
    .start_o (start_o),
    .rstart_o(rstart_o),
    .stop_o  (stop_o),
    .viol_o  (viol_o),
    .busy_o  (busy_o)
  );

  initial begin
    a_stages_r1: assert (SYNC_STAGES >= 1);
  end

  p_reset_idle_r8: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !start_o && !rstart_o && !stop_o && !viol_o);
endmodule

// File: tb/sim_i2c_cond_mon.sv
module sim_i2c_cond_mon;
  localparam int S    = 3;
  localparam int NCYC = 3000;
  localparam int HLEN = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda;
  logic start_w, rstart_w, stop_w, viol_w, busy_w;

  int checks = 0;
  int errors = 0;
  logic scl_h [HLEN];
  logic sda_h [HLEN];
  logic exp_busy;
  bit   done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  i2c_cond_mon #(.SYNC_STAGES(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .start_o(start_w), .rstart_o(rstart_w), .stop_o(stop_w),
    .viol_o(viol_w), .busy_o(busy_w)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // 0 none, 1 start, 2 stop, 3 violation
  function automatic int classify(logic cp, logic dp, logic cc, logic dc);
    if (dp == dc) return 0;
    if (cp != cc) return 3;           // R6
    if (!cc)      return 0;           // R7
    return dc ? 2 : 1;                // R2/R3/R4
  endfunction

  function automatic logic [1:0] directed(int d);
    if (d <= 3)  return 2'b11;
    if (d <= 5)  return 2'b10;   // start
    if (d <= 7)  return 2'b00;
    if (d == 8)  return 2'b01;   // sda moves, scl low
    if (d == 9)  return 2'b00;
    if (d == 10) return 2'b01;
    if (d <= 12) return 2'b11;
    if (d <= 14) return 2'b10;   // repeated start
    if (d == 15) return 2'b00;
    if (d <= 17) return 2'b10;
    if (d <= 19) return 2'b11;   // stop
    if (d <= 21) return 2'b01;
    if (d == 22) return 2'b00;
    if (d <= 24) return 2'b10;
    if (d <= 26) return 2'b11;   // stop while idle
    if (d == 27) return 2'b00;   // both move, idle
    if (d == 28) return 2'b11;   // both move
    if (d == 29) return 2'b10;   // start
    if (d == 30) return 2'b01;   // both move while busy
    return 2'b11;
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1c2d);
    for (int i = 0; i < HLEN; i++) begin
      scl_h[i] = 1'b1;
      sda_h[i] = 1'b1;
    end
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; exp_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "busy_o in reset", busy_w, 1'b0);
    chk("R8", "start_o in reset", start_w, 1'b0);
    chk("R8", "stop_o in reset", stop_w, 1'b0);
    chk("R8", "viol_o in reset", viol_w, 1'b0);
    rst_n = 1'b1;
    for (int n = 1; n <= NCYC; n++) begin
      logic cp, dp, cc, dc;
      int   ev;
      logic [1:0] nx;
      @(negedge clk);
      // R1: outputs after edge n reflect samples n-S and n-S-1
      cc = (n - S >= 1)     ? scl_h[n - S]     : 1'b1;
      dc = (n - S >= 1)     ? sda_h[n - S]     : 1'b1;
      cp = (n - S - 1 >= 1) ? scl_h[n - S - 1] : 1'b1;
      dp = (n - S - 1 >= 1) ? sda_h[n - S - 1] : 1'b1;
      ev = classify(cp, dp, cc, dc);
      chk("R2", "start_o", start_w, ev == 1 && !exp_busy);
      chk("R3", "rstart_o", rstart_w, ev == 1 && exp_busy);
      chk("R4", "stop_o", stop_w, ev == 2);
      chk("R6", "viol_o", viol_w, ev == 3);
      if (ev == 1) exp_busy = 1'b1;
      else if (ev == 2) exp_busy = 1'b0;
      chk("R5", "busy_o", busy_w, exp_busy);
      if (n + 1 < 40) nx = directed(n + 1);
      else begin
        nx = {scl, sda};
        case ($urandom_range(0, 7))
          0: nx[1] = ~nx[1];
          1: nx[0] = ~nx[0];
          2: nx = ~nx;
          default: ;
        endcase
      end
      if (n + 1 < HLEN) begin
        scl_h[n + 1] = nx[1];
        sda_h[n + 1] = nx[0];
      end
      scl = nx[1];
      sda = nx[0];
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule